// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This functional unit sits beside the integer ALU of a 32-bit RISC-V core and carries out the basic bit-manipulation subset. The core's decoder supplies a decoded operation code, the two source operands and the five-bit immediate used by the immediate rotate. On a one-cycle `start_i` pulse the unit computes the selected result combinationally and captures it in an output register. The result and `valid_o` appear in the following cycle. Between starts the output register keeps its value.

The operations fall into six groups:
- counting: leading zeros, trailing zeros and set bits;
- sign extension from a byte or a halfword, and zero extension of the low halfword;
- signed and unsigned minimum and maximum;
- AND, OR and XOR with the second operand inverted;
- left, right and immediate-right rotates;
- two fixed-control permutations: a byte-order reverse and a per-byte OR-combine.

Zero extension is a pack of the operand with a zero register. The byte reverse is a generalized reverse with control 24. The OR-combine is a generalized OR-combine with control 7.

The unit is present only when the `ENABLE` parameter is set, and the parameter is off by default. A disabled instance drives zeros on both outputs.

Top module: `bitmanip_unit`

## Requirements
- R1: `op_i` codes are 0 CLZ, 1 CTZ, 2 CPOP, 3 SEXT.B, 4 SEXT.H, 5 MIN, 6 MINU, 7 MAX, 8 MAXU, 9 ANDN, 10 ORN, 11 XNOR, 12 ROL, 13 ROR, 14 RORI, 15 ZEXT, 16 REV8, 17 ORC.B. `valid_o` is high exactly in the cycle after a cycle with `start_i` high and low otherwise, and `result_o` holds its value after a cycle without `start_i`.
- R2: CLZ counts zero bits above the highest set bit of `rs1_i`, CTZ counts zero bits below the lowest set bit, and both return 32 for a zero operand.
- R3: CPOP returns the number of set bits in `rs1_i`.
- R4: SEXT.B copies bit 7 of `rs1_i` into bits 31:8, and SEXT.H copies bit 15 into bits 31:16.
- R5: MIN and MAX compare the operands as two's-complement numbers, and MINU and MAXU compare them as unsigned numbers.
- R6: ANDN gives `rs1 & ~rs2`, ORN gives `rs1 | ~rs2`, and XNOR gives `~(rs1 ^ rs2)`.
- R7: ROL and ROR rotate `rs1_i` by `rs2_i[4:0]` and ignore the upper bits of `rs2_i`. RORI rotates right by `shamt_i`.
- R8: REV8 reverses the byte order of `rs1_i`.
- R9: ORC.B makes each result byte 0xFF when the matching source byte is nonzero, and 0x00 otherwise.
- R10: ZEXT keeps `rs1_i[15:0]` and clears bits 31:16.
- R11: The codes 18 to 31 give a result of zero.
- R12: With `ENABLE` at its default of 0, `valid_o` and `result_o` stay at zero whatever is applied.
- R13: While `rst_n` is low, `valid_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to execute |
| op_i | input | 5 | Decoded operation code |
| rs1_i | input | 32 | First source operand |
| rs2_i | input | 32 | Second source operand; its low 5 bits are the rotate amount |
| shamt_i | input | 5 | Immediate rotate amount for RORI |
| result_o | output | 32 | Registered result |
| valid_o | output | 1 | High in the cycle after a start |

## Verification
Two things can fall into the same cycle. One is the presentation of the previous result through `result_o` and `valid_o`. The other is the capture of the next request into the same output register. The bench provokes this by issuing starts on consecutive cycles, with randomly mixed operations, and by inserting occasional idle cycles between them. Each cycle is judged on its own: after a start, the output must show exactly that start's expected value. After an idle cycle, `valid_o` must be low and the last result must be unchanged, which shows that a new capture never disturbs or skips a result.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [4:0] {
    OP_CLZ   = 5'd0,
    OP_CTZ   = 5'd1,
    OP_CPOP  = 5'd2,
    OP_SEXTB = 5'd3,
    OP_SEXTH = 5'd4,
    OP_MIN   = 5'd5,
    OP_MINU  = 5'd6,
    OP_MAX   = 5'd7,
    OP_MAXU  = 5'd8,
    OP_ANDN  = 5'd9,
    OP_ORN   = 5'd10,
    OP_XNOR  = 5'd11,
    OP_ROL   = 5'd12,
    OP_ROR   = 5'd13,
    OP_RORI  = 5'd14,
    OP_ZEXT  = 5'd15,
    OP_REV8  = 5'd16,
    OP_ORCB  = 5'd17
  } bm_op_e;

  localparam int unsigned OP_W = 5;

endpackage

// File: rtl/bm_count.sv
module bm_count #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned CW  = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] val_i,
  output logic [CW-1:0]   lead_o,
  output logic [CW-1:0]   trail_o,
  output logic [CW-1:0]   ones_o
);

  // Ascending scan: the last hit is the highest set bit.
  always_comb begin
    lead_o = CW'(XLEN);
    for (int i = 0; i < XLEN; i++) begin
      if (val_i[i]) lead_o = CW'(XLEN - 1 - i);
    end
  end

  // Descending scan: the last hit is the lowest set bit.
  always_comb begin
    trail_o = CW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (val_i[i]) trail_o = CW'(i);
    end
  end

  always_comb begin
    ones_o = '0;
    for (int i = 0; i < XLEN; i++) begin
      ones_o = ones_o + CW'(val_i[i]);
    end
  end

endmodule

// File: rtl/bm_perm.sv
module bm_perm #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned LG  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [LG-1:0]   reg_amt_i,
  input  logic [LG-1:0]   imm_amt_i,
  output logic [XLEN-1:0] rol_o,
  output logic [XLEN-1:0] ror_o,
  output logic [XLEN-1:0] rori_o,
  output logic [XLEN-1:0] rev8_o,
  output logic [XLEN-1:0] orcb_o
);

  localparam logic [LG-1:0] REV_CTL = LG'(XLEN - 8);
  localparam logic [LG-1:0] ORC_CTL = LG'(7);

  logic [2*XLEN-1:0] dbl;
  logic [2*XLEN-1:0] left_sh;
  logic [2*XLEN-1:0] right_sh;
  logic [2*XLEN-1:0] right_imm;

  assign dbl       = {val_i, val_i};
  assign left_sh   = dbl << reg_amt_i;
  assign right_sh  = dbl >> reg_amt_i;
  assign right_imm = dbl >> imm_amt_i;
  assign rol_o     = left_sh[2*XLEN-1:XLEN];
  assign ror_o     = right_sh[XLEN-1:0];
  assign rori_o    = right_imm[XLEN-1:0];

  // Exchange each pair of neighbouring blocks of 2**lvl bits.
  function automatic logic [XLEN-1:0] swap_blocks(input logic [XLEN-1:0] x, input int lvl);
    logic [XLEN-1:0] y;
    for (int i = 0; i < XLEN; i++) begin
      y[i] = x[i ^ (1 << lvl)];
    end
    return y;
  endfunction

  logic [XLEN-1:0] rev_st [LG+1];
  logic [XLEN-1:0] orc_st [LG+1];

  assign rev_st[0] = val_i;
  assign orc_st[0] = val_i;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    if (REV_CTL[s]) begin : g_rev_on
      assign rev_st[s+1] = swap_blocks(rev_st[s], s);
    end else begin : g_rev_off
      assign rev_st[s+1] = rev_st[s];
    end
    if (ORC_CTL[s]) begin : g_orc_on
      assign orc_st[s+1] = orc_st[s] | swap_blocks(orc_st[s], s);
    end else begin : g_orc_off
      assign orc_st[s+1] = orc_st[s];
    end
  end

  assign rev8_o = rev_st[LG];
  assign orcb_o = orc_st[LG];

endmodule

// File: rtl/bm_arith.sv
module bm_arith #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] min_o,
  output logic [XLEN-1:0] max_o,
  output logic [XLEN-1:0] minu_o,
  output logic [XLEN-1:0] maxu_o,
  output logic [XLEN-1:0] andn_o,
  output logic [XLEN-1:0] orn_o,
  output logic [XLEN-1:0] xnor_o,
  output logic [XLEN-1:0] sextb_o,
  output logic [XLEN-1:0] sexth_o,
  output logic [XLEN-1:0] zext_o
);

  logic lt_s;
  logic lt_u;

  assign lt_u = a_i < b_i;
  assign lt_s = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : lt_u;

  assign min_o   = lt_s ? a_i : b_i;
  assign max_o   = lt_s ? b_i : a_i;
  assign minu_o  = lt_u ? a_i : b_i;
  assign maxu_o  = lt_u ? b_i : a_i;
  assign andn_o  = a_i & ~b_i;
  assign orn_o   = a_i | ~b_i;
  assign xnor_o  = ~(a_i ^ b_i);
  assign sextb_o = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
  assign sexth_o = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
  assign zext_o  = {{(XLEN-HALF){1'b0}}, a_i[HALF-1:0]};

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit #(
  parameter int unsigned XLEN   = 32,
  parameter bit          ENABLE = 1'b0,
  localparam int unsigned LG    = $clog2(XLEN),
  localparam int unsigned CW    = LG + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [4:0]      op_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [LG-1:0]   shamt_i,
  output logic [XLEN-1:0] result_o,
  output logic            valid_o
);

  import bm_pkg::*;

  if (ENABLE) begin : g_unit
    logic [CW-1:0]   lead, trail, ones;
    logic [XLEN-1:0] rol_r, ror_r, rori_r, rev8_r, orcb_r;
    logic [XLEN-1:0] min_r, max_r, minu_r, maxu_r;
    logic [XLEN-1:0] andn_r, orn_r, xnor_r, sextb_r, sexth_r, zext_r;
    logic [XLEN-1:0] res_d, res_q;
    logic            vld_d, vld_q;

    bm_count #(.XLEN(XLEN)) u_count (
      .val_i  (rs1_i),
      .lead_o (lead),
      .trail_o(trail),
      .ones_o (ones)
    );

    bm_perm #(.XLEN(XLEN)) u_perm (
      .val_i    (rs1_i),
      .reg_amt_i(rs2_i[LG-1:0]),
      .imm_amt_i(shamt_i),
      .rol_o    (rol_r),
      .ror_o    (ror_r),
      .rori_o   (rori_r),
      .rev8_o   (rev8_r),
      .orcb_o   (orcb_r)
    );

    bm_arith #(.XLEN(XLEN)) u_arith (
      .a_i    (rs1_i),
      .b_i    (rs2_i),
      .min_o  (min_r),
      .max_o  (max_r),
      .minu_o (minu_r),
      .maxu_o (maxu_r),
      .andn_o (andn_r),
      .orn_o  (orn_r),
      .xnor_o (xnor_r),
      .sextb_o(sextb_r),
      .sexth_o(sexth_r),
      .zext_o (zext_r)
    );

    // Next-state: select the result and decide whether to capture it.
    always_comb begin
      res_d = '0;
      case (op_i)
        OP_CLZ:   res_d = XLEN'(lead);
        OP_CTZ:   res_d = XLEN'(trail);
        OP_CPOP:  res_d = XLEN'(ones);
        OP_SEXTB: res_d = sextb_r;
        OP_SEXTH: res_d = sexth_r;
        OP_MIN:   res_d = min_r;
        OP_MINU:  res_d = minu_r;
        OP_MAX:   res_d = max_r;
        OP_MAXU:  res_d = maxu_r;
        OP_ANDN:  res_d = andn_r;
        OP_ORN:   res_d = orn_r;
        OP_XNOR:  res_d = xnor_r;
        OP_ROL:   res_d = rol_r;
        OP_ROR:   res_d = ror_r;
        OP_RORI:  res_d = rori_r;
        OP_ZEXT:  res_d = zext_r;
        OP_REV8:  res_d = rev8_r;
        OP_ORCB:  res_d = orcb_r;
        default:  res_d = '0;
      endcase
      vld_d = start_i;
    end

    // Registers: the result is captured only when start_i acts as the enable.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
        if (start_i) res_q <= res_d;
      end
    end

    assign result_o = res_q;
    assign valid_o  = vld_q;
  end else begin : g_absent
    logic unused;
    assign unused   = ^{clk, rst_n, start_i, op_i, rs1_i, rs2_i, shamt_i};
    assign result_o = '0;
    assign valid_o  = 1'b0;
  end

endmodule

// File: rtl/bitmanip_unit_chk.sv
module bitmanip_unit_chk #(
  parameter int unsigned XLEN   = 32,
  parameter bit          ENABLE = 1'b0,
  localparam int unsigned LG    = $clog2(XLEN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [4:0]      op_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [LG-1:0]   shamt_i,
  input logic [XLEN-1:0] result_o,
  input logic            valid_o
);

  import bm_pkg::*;

  function automatic bit bytes_saturated(input logic [XLEN-1:0] x);
    bit ok = 1'b1;
    for (int k = 0; k < XLEN / 8; k++) begin
      if (x[8*k +: 8] != 8'h00 && x[8*k +: 8] != 8'hFF) ok = 1'b0;
    end
    return ok;
  endfunction

  if (ENABLE) begin : g_on
    // R1
    valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !valid_o);

    // R1
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(result_o));

    // R2
    clz_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == OP_CLZ && rs1_i == '0) |=> result_o == XLEN'(XLEN));

    // R4
    sextb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == OP_SEXTB) |=>
        result_o == {{(XLEN-8){$past(rs1_i[7])}}, $past(rs1_i[7:0])});

    // R9
    orcb_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == OP_ORCB) |=> bytes_saturated(result_o));

    // R13
    always @(posedge clk) begin
      if (!rst_n) begin
        reset_quiet_chk: assert (!valid_o && result_o == '0);
      end
    end
  end else begin : g_off
    // R12
    absent_quiet_chk: assert property (@(posedge clk)
      !valid_o && result_o == '0);
  end

endmodule

bind bitmanip_unit bitmanip_unit_chk #(.XLEN(XLEN), .ENABLE(ENABLE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .op_i    (op_i),
  .rs1_i   (rs1_i),
  .rs2_i   (rs2_i),
  .shamt_i (shamt_i),
  .result_o(result_o),
  .valid_o (valid_o)
);

// File: tb/sim_bitmanip_unit.sv
`timescale 1ns/1ps
module sim_bitmanip_unit;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [4:0]  op;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [31:0] res, res_off;
  logic        vld, vld_off;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bitmanip_unit #(.XLEN(32), .ENABLE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .rs1_i(a), .rs2_i(b), .shamt_i(sh), .result_o(res), .valid_o(vld)
  );

  bitmanip_unit u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .rs1_i(a), .rs2_i(b), .shamt_i(sh), .result_o(res_off), .valid_o(vld_off)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      0, 1:       return "R2";
      2:          return "R3";
      3, 4:       return "R4";
      5, 6, 7, 8: return "R5";
      9, 10, 11:  return "R6";
      12, 13, 14: return "R7";
      15:         return "R10";
      16:         return "R8";
      17:         return "R9";
      default:    return "R11";
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [4:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [4:0] s);
    logic [31:0] r = '0;
    int n;
    case (o)
      0: begin n = 0; while (n < 32 && !x[31-n]) n++; r = n; end
      1: begin n = 0; while (n < 32 && !x[n]) n++; r = n; end
      2: begin n = 0; for (int i = 0; i < 32; i++) n += x[i]; r = n; end
      3: r = 32'($signed(x[7:0]));
      4: r = 32'($signed(x[15:0]));
      5: r = ($signed(x) < $signed(y)) ? x : y;
      6: r = (x < y) ? x : y;
      7: r = ($signed(x) > $signed(y)) ? x : y;
      8: r = (x > y) ? x : y;
      9: r = x & ~y;
      10: r = x | ~y;
      11: r = x ~^ y;
      12: begin r = x; for (int i = 0; i < int'(y[4:0]); i++) r = {r[30:0], r[31]}; end
      13: begin r = x; for (int i = 0; i < int'(y[4:0]); i++) r = {r[0], r[31:1]}; end
      14: begin r = x; for (int i = 0; i < int'(s); i++) r = {r[0], r[31:1]}; end
      15: r = {16'h0, x[15:0]};
      16: r = {x[7:0], x[15:8], x[23:16], x[31:24]};
      17: for (int k = 0; k < 4; k++) r[8*k +: 8] = (x[8*k +: 8] != 0) ? 8'hFF : 8'h00;
      default: r = '0;
    endcase
    return r;
  endfunction

  bit          pend = 0;
  logic [31:0] pend_exp = '0;
  logic [4:0]  pend_op = '0;
  logic [31:0] last = '0;

  task automatic step(input bit go, input logic [4:0] o, input logic [31:0] x,
                      input logic [31:0] y, input logic [4:0] s);
    @(negedge clk);
    if (pend) begin
      chk("R1 valid after start", {31'b0, vld}, 32'd1);
      chk(tag_of(pend_op), res, pend_exp);
      last = pend_exp;
    end else begin
      chk("R1 valid idle", {31'b0, vld}, 32'd0);
      chk("R1 hold", res, last);
    end
    chk("R12 disabled", res_off | {31'b0, vld_off}, 32'd0);
    start = go; op = o; a = x; b = y; sh = s;
    pend = go;
    if (go) begin
      pend_exp = model(o, x, y, s);
      pend_op  = o;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    rst_n = 1'b0; start = 1'b0; op = '0; a = '0; b = '0; sh = '0;
    seed = $urandom(32'h5A17_C0DE);
    repeat (3) @(negedge clk);
    chk("R13 reset valid", {31'b0, vld}, 32'd0);
    chk("R13 reset result", res, 32'd0);
    rst_n = 1'b1;

    // Directed corners.
    step(1, 0,  32'h0000_0000, 0, 0);             // R2 CLZ of zero
    step(1, 1,  32'h0000_0000, 0, 0);             // R2 CTZ of zero
    step(1, 0,  32'h8000_0000, 0, 0);             // R2
    step(1, 1,  32'h8000_0000, 0, 0);             // R2
    step(1, 2,  32'hFFFF_FFFF, 0, 0);             // R3
    step(1, 3,  32'h1234_5680, 0, 0);             // R4
    step(1, 4,  32'h0000_8001, 0, 0);             // R4
    step(1, 5,  32'hFFFF_FFFE, 32'h0000_0003, 0); // R5 signed min
    step(1, 6,  32'hFFFF_FFFE, 32'h0000_0003, 0); // R5 unsigned min
    step(1, 7,  32'h8000_0000, 32'h7FFF_FFFF, 0); // R5
    step(1, 12, 32'h8000_0001, 32'h0000_0021, 0); // R7 upper amount bits ignored
    step(1, 13, 32'h0000_0003, 32'hFFFF_FFE1, 0); // R7
    step(1, 14, 32'hDEAD_BEEF, 32'h0000_0004, 0); // R7 RORI by 0 ignores rs2
    step(0, 0, 0, 0, 0);
    step(1, 16, 32'h1122_3344, 0, 0);             // R8
    step(1, 17, 32'h0001_0080, 0, 0);             // R9
    step(1, 15, 32'hABCD_8765, 0, 0);             // R10
    step(1, 9,  32'hF0F0_F0F0, 32'hFF00_FF00, 0); // R6
    step(1, 25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31); // R11
    step(0, 0, 0, 0, 0);

    // Constrained random mix, with back-to-back starts and idle gaps.
    for (int n = 0; n < 600; n++) begin
      logic [4:0]  o;
      logic [31:0] x, y;
      int          sel;
      o = 5'($urandom_range(0, 20));
      sel = $urandom_range(0, 3);
      x = (sel == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      y = $urandom;
      step($urandom_range(0, 4) != 0, o, x, y, 5'($urandom));
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule